// File: doc/BRIEF.md
# Pipelined Prioritized Interrupt Controller

This block sits beside a processor's program sequencer and decides when the sequencer must branch to an interrupt service routine. Four external request lines and a timer tick are sampled each clock, and a rising edge on any of them sets a bit in a pending-latch register. Software can also set bits in that register through a small register port. Each cycle the controller compares the pending bits against an interrupt mask, a global enable and a nesting pointer. It picks the highest-priority candidate and, two cycles later, gives the sequencer a one-cycle branch strobe. The strobe carries the vector address and the stack push requests.

The response runs in three fixed stages: latch, recognize, then a two-cycle branch. A mask write reaches recognition one cycle after the write, so the exact window in which a masking or unmasking write still lets an interrupt through is visible at the pins. The nesting pointer records which priority levels are in service. A return strobe from the sequencer releases the most urgent active level. A nesting-mode bit selects whether an active level blocks every request or only requests of equal and lower priority.

The branch strobe is a plain control output with no valid/ready pairing. The sequencer cannot hold it off, so there is no back-pressure. The register port is a simple synchronous read and write port.

Top module: `irq_pipe_ctrl`

## Requirements
- R1: After reset the pending, mask, control and nest registers all read zero, and no branch strobe is given.
- R2: A rising edge on an enabled, unmasked external or timer line that is sampled at clock edge k gives a branch strobe in the cycle after edge k+3. The strobe is preceded by one recognition cycle and two branch cycles.
- R3: A software write to the pending register (address 0) at edge k sets the written bits, which are recognized at edge k+1 and branched to after edge k+3.
- R4: A mask-register write takes effect on recognition one edge late. A request latched at the same edge as a mask write of 0 is still taken. A pending request is taken when a mask write of 1 is followed at once by a write of 0.
- R5: Among the candidates, the lowest-numbered bit wins. Its pending bit is cleared when it is recognized, and the other pending bits stay set.
- R6: The strobe carries vector = VEC_BASE + index * VEC_STRIDE and always requests a PC push. It requests a status push only for the external lines (bits 0..3) and the timer (bit 4); bits 5..7 are software-only.
- R7: On entry, the serviced bit is set in the nest register. With nesting mode 1, requests of equal or lower priority (equal or higher index) are blocked. With nesting mode 0, every request is blocked while any nest bit is set.
- R8: A return strobe clears the lowest-numbered set nest bit, which unblocks the requests it was holding back.
- R9: While the global enable is 0, the pending register is cleared on the next edge, software writes to it do not stick, and nothing is recognized. Requests dropped this way are not served after the enable returns.
- R10: The register map is: address 0 pending, 1 mask (bit = 1 lets that interrupt through), 2 control (bit 0 global enable, bit 1 nesting mode), 3 nest (read-only, writes ignored). Read data is registered one cycle after the address.
- R11: While a request is between recognition and its branch strobe, no other request is recognized, so branch strobes are at least three cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_irq | input | N_EXT (4) | External request lines, edge-sensed |
| timer_irq | input | 1 | Timer request line, edge-sensed |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | N_IRQ (8) | Register write data |
| reg_we | input | 1 | Register write enable |
| reg_rdata | output | N_IRQ (8) | Registered read data |
| rti | input | 1 | Return-from-interrupt strobe |
| br_valid | output | 1 | One-cycle branch-to-vector strobe |
| br_vector | output | VEC_W (12) | Vector address, zero when no strobe |
| push_pc | output | 1 | Request to push the return address |
| push_status | output | 1 | Request to push the status and mode registers |

## Verification
A stimulus applied before edge k shows its branch strobe after edge k+3. For a mask write before edge k that opens a pending request, the strobe appears only after edge k+4. Register reads return one cycle after the address is presented. The bench drives every input just after a falling edge and counts falling edges from the stimulus. It checks for the strobe at the exact falling edge where it is due and checks that it is absent at the one before. Where only order matters (priority, nesting, and the random pending patterns), it waits a bounded number of cycles for each strobe and compares the vector with the value the bench computes.

// File: rtl/irq_pipe_pkg.sv
package irq_pipe_pkg;
  typedef enum logic [1:0] {
    REG_PEND = 2'd0,
    REG_MASK = 2'd1,
    REG_CTRL = 2'd2,
    REG_NEST = 2'd3
  } irq_reg_e;

  localparam int CTRL_GIE_BIT  = 0;
  localparam int CTRL_NEST_BIT = 1;
endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch #(
  parameter int N_EXT = 4,
  parameter int N_IRQ = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EXT-1:0] ext_lines,
  input  logic             timer_line,
  input  logic             sw_we,
  input  logic [N_IRQ-1:0] sw_data,
  input  logic             gie,
  input  logic [N_IRQ-1:0] clr_vec,
  output logic [N_IRQ-1:0] pend
);
  localparam int N_HW = N_EXT + 1;

  logic [N_HW-1:0]  hw_now, hw_prev;
  logic [N_IRQ-1:0] rise;

  assign hw_now = {timer_line, ext_lines};
  assign rise   = N_IRQ'(hw_now & ~hw_prev);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hw_prev <= '0;
      pend    <= '0;
    end else begin
      hw_prev <= hw_now;
      if (!gie) pend <= '0;
      else      pend <= ((sw_we ? sw_data : pend) | rise) & ~clr_vec;
    end
  end

  // R9: a disabled controller holds nothing pending
  p_pend_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |=> pend == '0);

  // R3: software-written bits stick unless taken at that same edge
  p_sw_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (gie && sw_we) |=> ((pend | $past(clr_vec)) & $past(sw_data)) == $past(sw_data));
endmodule

// File: rtl/irq_recognize.sv
module irq_recognize #(
  parameter int N_IRQ = 8,
  localparam int IW = $clog2(N_IRQ)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IRQ-1:0] pend,
  input  logic [N_IRQ-1:0] mask_q,
  input  logic             gie,
  input  logic [N_IRQ-1:0] nest_block,
  input  logic             busy,
  output logic [N_IRQ-1:0] clr_vec,
  output logic             rec_valid,
  output logic [IW-1:0]    rec_idx
);
  logic [N_IRQ-1:0] mask_eff, cand;
  logic [IW-1:0]    winner;
  logic             fire;

  assign cand = pend & mask_eff & ~nest_block & {N_IRQ{gie}};
  assign fire = (|cand) && !busy;

  always_comb begin
    winner = '0;
    for (int i = N_IRQ - 1; i >= 0; i--)
      if (cand[i]) winner = IW'(i);
  end

  assign clr_vec = fire ? (N_IRQ'(1) << winner) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_eff  <= '0;
      rec_valid <= 1'b0;
      rec_idx   <= '0;
    end else begin
      mask_eff  <= mask_q;
      rec_valid <= fire;
      rec_idx   <= winner;
    end
  end

  // R4: the mask seen by recognition lags the architected mask by one edge
  p_mask_lag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> ((($past(mask_q, 2)) >> rec_idx) & N_IRQ'(1)) != '0);
endmodule

// File: rtl/irq_nest_track.sv
module irq_nest_track #(
  parameter int N_IRQ = 8,
  localparam int IW = $clog2(N_IRQ)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enter,
  input  logic [IW-1:0]    enter_idx,
  input  logic             rti,
  input  logic             nest_mode,
  output logic [N_IRQ-1:0] nest,
  output logic [N_IRQ-1:0] block
);
  logic [N_IRQ-1:0] top_bit, popped;

  assign top_bit = nest & (~nest + N_IRQ'(1));
  assign popped  = rti ? (nest & ~top_bit) : nest;

  always_ff @(posedge clk) begin
    if (!rst_n) nest <= '0;
    else        nest <= popped | (enter ? (N_IRQ'(1) << enter_idx) : '0);
  end

  for (genvar j = 0; j < N_IRQ; j++) begin : g_block
    assign block[j] = nest_mode ? (|nest[j:0]) : (|nest);
  end

  // R8: a return removes exactly one active level
  p_rti_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rti && !enter && nest != '0) |=> $countones(nest) == $countones($past(nest)) - 1);

  // R7: an entered level is recorded
  p_enter_mark_r7: assert property (@(posedge clk) disable iff (!rst_n)
    enter |=> ((nest >> $past(enter_idx)) & N_IRQ'(1)) != '0);
endmodule

// File: rtl/irq_pipe_ctrl.sv
module irq_pipe_ctrl
  import irq_pipe_pkg::*;
#(
  parameter int N_EXT      = 4,
  parameter int N_IRQ      = 8,
  parameter int VEC_W      = 12,
  parameter int VEC_BASE   = 32,
  parameter int VEC_STRIDE = 8,
  localparam int IW = $clog2(N_IRQ)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EXT-1:0] ext_irq,
  input  logic             timer_irq,
  input  logic [1:0]       reg_addr,
  input  logic [N_IRQ-1:0] reg_wdata,
  input  logic             reg_we,
  output logic [N_IRQ-1:0] reg_rdata,
  input  logic             rti,
  output logic             br_valid,
  output logic [VEC_W-1:0] br_vector,
  output logic             push_pc,
  output logic             push_status
);
  localparam logic [IW-1:0]    LAST_STATUS = IW'(N_EXT);
  localparam logic [VEC_W-1:0] VBASE       = VEC_W'(VEC_BASE);
  localparam logic [VEC_W-1:0] VSTEP       = VEC_W'(VEC_STRIDE);

  logic [N_IRQ-1:0] mask_q, pend, clr_vec, nest, nest_block;
  logic             gie_q, nmode_q;
  logic             rec_valid, br1_q, br_q;
  logic [IW-1:0]    rec_idx, br1_idx, br_idx_q;
  logic             we_pend, we_mask, we_ctrl;

  assign we_pend = reg_we && (reg_addr == REG_PEND);
  assign we_mask = reg_we && (reg_addr == REG_MASK);
  assign we_ctrl = reg_we && (reg_addr == REG_CTRL);

  irq_edge_latch #(.N_EXT(N_EXT), .N_IRQ(N_IRQ)) u_latch (
    .clk(clk), .rst_n(rst_n), .ext_lines(ext_irq), .timer_line(timer_irq),
    .sw_we(we_pend), .sw_data(reg_wdata), .gie(gie_q), .clr_vec(clr_vec),
    .pend(pend)
  );

  irq_recognize #(.N_IRQ(N_IRQ)) u_rec (
    .clk(clk), .rst_n(rst_n), .pend(pend), .mask_q(mask_q), .gie(gie_q),
    .nest_block(nest_block), .busy(rec_valid | br1_q), .clr_vec(clr_vec),
    .rec_valid(rec_valid), .rec_idx(rec_idx)
  );

  irq_nest_track #(.N_IRQ(N_IRQ)) u_nest (
    .clk(clk), .rst_n(rst_n), .enter(br1_q), .enter_idx(br1_idx),
    .rti(rti), .nest_mode(nmode_q), .nest(nest), .block(nest_block)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q    <= '0;
      gie_q     <= 1'b0;
      nmode_q   <= 1'b0;
      br1_q     <= 1'b0;
      br1_idx   <= '0;
      br_q      <= 1'b0;
      br_idx_q  <= '0;
      reg_rdata <= '0;
    end else begin
      if (we_mask) mask_q <= reg_wdata;
      if (we_ctrl) begin
        gie_q   <= reg_wdata[CTRL_GIE_BIT];
        nmode_q <= reg_wdata[CTRL_NEST_BIT];
      end
      br1_q    <= rec_valid;
      br1_idx  <= rec_idx;
      br_q     <= br1_q;
      br_idx_q <= br1_idx;
      case (irq_reg_e'(reg_addr))
        REG_PEND: reg_rdata <= pend;
        REG_MASK: reg_rdata <= mask_q;
        REG_CTRL: begin
          reg_rdata                <= '0;
          reg_rdata[CTRL_GIE_BIT]  <= gie_q;
          reg_rdata[CTRL_NEST_BIT] <= nmode_q;
        end
        default:  reg_rdata <= nest;
      endcase
    end
  end

  assign br_valid    = br_q;
  assign push_pc     = br_q;
  assign push_status = br_q && (br_idx_q <= LAST_STATUS);
  assign br_vector   = br_q ? (VBASE + VEC_W'(br_idx_q) * VSTEP) : '0;

  // R11: only one request travels the recognize/branch stages at a time
  p_one_in_flight_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rec_valid, br1_q, br_q}));

  // R2: a recognized request reaches the first branch stage with its index
  p_rec_to_branch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |=> (br1_q && br1_idx == $past(rec_idx)));

  // R6: a status push never comes without a PC push
  p_status_with_pc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    push_status |-> push_pc);

  // R9: nothing is recognized while globally disabled
  p_quiet_when_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !gie_q |=> !rec_valid);
endmodule

// File: tb/irq_pipe_ctrl_test.sv
module irq_pipe_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int VEC_BASE   = 32;
  localparam int VEC_STRIDE = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] ext_irq = '0;
  logic       timer_irq = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_rdata;
  logic       rti = 1'b0;
  logic       br_valid;
  logic [11:0] br_vector;
  logic       push_pc, push_status;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  irq_pipe_ctrl uut (
    .clk(clk), .rst_n(rst_n), .ext_irq(ext_irq), .timer_irq(timer_irq),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_rdata(reg_rdata), .rti(rti), .br_valid(br_valid),
    .br_vector(br_vector), .push_pc(push_pc), .push_status(push_status)
  );

  function automatic logic [11:0] exp_vec(int idx);
    return 12'(VEC_BASE + idx * VEC_STRIDE);
  endfunction

  function automatic logic exp_stat(int idx);
    return idx <= 4;
  endfunction

  function automatic int lowest(logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return -1;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a; reg_we = 1'b0;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic do_rti();
    rti = 1'b1;
    @(negedge clk);
    rti = 1'b0;
  endtask

  task automatic wait_br(input int limit, output bit found);
    found = 1'b0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (br_valid) begin found = 1'b1; break; end
    end
  endtask

  task automatic expect_br(input string req, input int idx);
    bit f;
    wait_br(20, f);
    check(f, req, 0, 1);
    check(br_vector == exp_vec(idx), req, br_vector, exp_vec(idx));
    check(push_pc == 1'b1, req, push_pc, 1);
    check(push_status == exp_stat(idx), req, push_status, exp_stat(idx));
  endtask

  task automatic expect_quiet(input string req, input int n);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (br_valid) seen++;
    end
    check(seen == 0, req, seen, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    bit f;
    void'($urandom(32'd4242));
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R1: reset values
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      check(d == 8'h00, "R1 reset register", d, 0);
    end
    check(br_valid == 1'b0, "R1 no strobe", br_valid, 0);

    // R10: register map
    wr(2'd2, 8'h03); rd(2'd2, d);
    check(d == 8'h03, "R10 control readback", d, 3);
    wr(2'd3, 8'hFF); rd(2'd3, d);
    check(d == 8'h00, "R10 nest write ignored", d, 0);
    wr(2'd1, 8'hFF); rd(2'd1, d);
    check(d == 8'hFF, "R10 mask readback", d, 8'hFF);
    tick(2);

    // R2: external edge, exact timing
    ext_irq = 4'b0100;
    tick(3); check(br_valid == 1'b0, "R2 early strobe", br_valid, 0);
    tick(1); check(br_valid == 1'b1, "R2 strobe at k+3", br_valid, 1);
    check(br_vector == exp_vec(2), "R2 vector", br_vector, exp_vec(2));
    check(push_status == 1'b1, "R6 status push ext", push_status, 1);
    ext_irq = '0;
    do_rti(); tick(2);

    // R3: software-set bit, exact timing; R6 no status push
    reg_addr = 2'd0; reg_wdata = 8'h40; reg_we = 1'b1;
    tick(1); reg_we = 1'b0;
    tick(2); check(br_valid == 1'b0, "R3 early strobe", br_valid, 0);
    tick(1); check(br_valid == 1'b1, "R3 strobe at k+3", br_valid, 1);
    check(br_vector == exp_vec(6), "R3 vector", br_vector, exp_vec(6));
    check(push_status == 1'b0, "R6 no status push sw", push_status, 0);
    do_rti(); tick(2);

    // R5: priority and clearing of the taken bit
    wr(2'd1, 8'h00); tick(2);
    wr(2'd0, 8'h28); rd(2'd0, d);
    check(d == 8'h28, "R5 pending held while masked", d, 8'h28);
    wr(2'd1, 8'hFF);
    expect_br("R5 first winner", 3);
    rd(2'd0, d);
    check(d == 8'h20, "R5 taken bit cleared", d, 8'h20);
    do_rti();
    expect_br("R5 second winner", 5);
    do_rti(); tick(2);

    // R4: opening the mask shows one edge late
    wr(2'd1, 8'h00); tick(2);
    wr(2'd0, 8'h02); tick(2);
    reg_addr = 2'd1; reg_wdata = 8'hFF; reg_we = 1'b1;
    tick(1); reg_we = 1'b0;
    tick(3); check(br_valid == 1'b0, "R4 unmask lag early", br_valid, 0);
    tick(1); check(br_valid == 1'b1, "R4 unmask lag strobe", br_valid, 1);
    check(br_vector == exp_vec(1), "R4 unmask vector", br_vector, exp_vec(1));
    do_rti(); tick(2);

    // R4: request latched at the same edge as a masking write is still taken
    ext_irq = 4'b0001; reg_addr = 2'd1; reg_wdata = 8'h00; reg_we = 1'b1;
    tick(1); reg_we = 1'b0;
    tick(2); check(br_valid == 1'b0, "R4 mask window early", br_valid, 0);
    tick(1); check(br_valid == 1'b1, "R4 mask window taken", br_valid, 1);
    check(br_vector == exp_vec(0), "R4 mask window vector", br_vector, exp_vec(0));
    ext_irq = '0;
    do_rti(); tick(2);

    // R4: open then close at once still serves a pending request
    wr(2'd0, 8'h04); tick(2);
    reg_addr = 2'd1; reg_wdata = 8'hFF; reg_we = 1'b1;
    tick(1); reg_wdata = 8'h00;
    tick(1); reg_we = 1'b0;
    tick(2); check(br_valid == 1'b0, "R4 pulse window early", br_valid, 0);
    tick(1); check(br_valid == 1'b1, "R4 pulse window taken", br_valid, 1);
    check(br_vector == exp_vec(2), "R4 pulse window vector", br_vector, exp_vec(2));
    do_rti(); tick(2);

    // R7/R8: nested mode blocks equal and lower priority only
    wr(2'd1, 8'hFF); tick(2);
    timer_irq = 1'b1;
    expect_br("R7 timer entry", 4);
    wr(2'd0, 8'h40);
    expect_quiet("R7 lower priority blocked", 10);
    ext_irq = 4'b0010;
    expect_br("R7 higher priority preempts", 1);
    rd(2'd3, d);
    check(d == 8'h12, "R7 nest two levels", d, 8'h12);
    do_rti(); rd(2'd3, d);
    check(d == 8'h10, "R8 pop most urgent", d, 8'h10);
    expect_quiet("R8 still blocked", 8);
    do_rti();
    expect_br("R8 unblocked after pop", 6);
    do_rti();
    timer_irq = 1'b0; ext_irq = '0; tick(2);

    // R7: non-nested mode blocks everything
    wr(2'd2, 8'h01); tick(1);
    wr(2'd0, 8'h08);
    expect_br("R7 flat entry", 3);
    wr(2'd0, 8'h01);
    expect_quiet("R7 flat blocks higher", 8);
    do_rti();
    expect_br("R7 flat after return", 0);
    do_rti(); tick(2);

    // R11: back-to-back requests spaced by the in-flight window
    wr(2'd2, 8'h03); tick(1);
    reg_addr = 2'd0; reg_wdata = 8'h20; reg_we = 1'b1;
    tick(1); reg_we = 1'b0; ext_irq = 4'b0100;
    tick(3); check(br_valid == 1'b1 && br_vector == exp_vec(5), "R11 first strobe", br_vector, exp_vec(5));
    tick(1); check(br_valid == 1'b0, "R11 gap 1", br_valid, 0);
    tick(1); check(br_valid == 1'b0, "R11 gap 2", br_valid, 0);
    tick(1); check(br_valid == 1'b1 && br_vector == exp_vec(2), "R11 second strobe", br_vector, exp_vec(2));
    ext_irq = '0;
    do_rti(); do_rti(); tick(2);

    // R9: disable drops pending requests for good
    wr(2'd1, 8'h00); tick(2);
    wr(2'd0, 8'h80); rd(2'd0, d);
    check(d == 8'h80, "R9 pending before disable", d, 8'h80);
    wr(2'd2, 8'h00); tick(1); rd(2'd0, d);
    check(d == 8'h00, "R9 cleared when disabled", d, 0);
    wr(2'd0, 8'h01); rd(2'd0, d);
    check(d == 8'h00, "R9 write ignored when disabled", d, 0);
    wr(2'd2, 8'h01); wr(2'd1, 8'hFF);
    expect_quiet("R9 dropped not served", 10);

    // R5/R6: random pending patterns, flat mode, served in priority order
    for (int it = 0; it < 25; it++) begin
      logic [7:0] rem;
      rem = 8'($urandom_range(1, 255));
      wr(2'd0, rem);
      while (rem != 0) begin
        int w;
        w = lowest(rem);
        expect_br("R5 random order", w);
        rem[w] = 1'b0;
        do_rti();
      end
      wait_br(6, f);
      check(!f, "R5 random no extra strobe", f, 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule